// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the device-side front end of a serial flash that recognises single-byte instructions and keeps the 8-bit status register. The host controls it with SCK, an active-low chip select and a serial data line. The controller accepts write-enable, status-write and status-read instructions. It also accepts two instructions that enter and leave a byte-wide mode, in which the status byte moves over an 8-bit port instead of the serial lines.

Status writes pass two gates. The first is the write-enable latch. The second is a hardware lock, formed by the lock bit of the register together with an external write-protect pin. Some bits of the register cannot be written by the host. An accepted write starts a fixed-length busy period, which models the internal write cycle. When that period ends, the write-enable latch clears. All host lines are sampled with the system clock `clk_i`.

Status byte layout, MSB to LSB: bit 7 write lock, bits 6:5 always zero, bits 4:2 protection field, bit 1 write-enable latch, bit 0 busy.

Top module: `sflash_status_ctrl`

## Requirements
- R1: After reset the status byte is 00h, byte-wide mode is off, and both `so_oe_o` and `pdat_oe_o` are low.
- R2: While `cs_ni` is low, bits are taken from `si_i` on rising SCK edges, MSB first. SCK may idle low (mode 0) or high (mode 3) when `cs_ni` falls.
- R3: Instruction 06h, followed by `cs_ni` rising after exactly 8 edges while bit 0 is clear, sets bit 1. A status write never writes bit 1.
- R4: Instruction 01h updates bit 7 and bits 4:2 from its data byte only under all of these conditions: bit 1 is set, bit 0 is clear, and `cs_ni` rises after exactly 16 edges (serial) or exactly 9 edges (byte-wide). In every other case nothing changes.
- R5: Bits 6:5 always read 0. Bit 0 is never taken from written data.
- R6: If bit 7 is 1 and `wp_ni` is low when `cs_ni` rises, a status write is ignored.
- R7: An accepted write raises bit 0 in the cycle after `cs_ni` is seen high. Bit 0 stays high for BUSY_CYCLES clock cycles. When it falls, bit 1 clears.
- R8: While bit 0 is set, instructions 06h and 01h have no effect.
- R9: Instruction 05h in serial mode enables SO from the 8th rising edge until `cs_ni` rises. SO changes on falling SCK edges, MSB first. The byte is captured at each 8th rising edge and sent repeatedly.
- R10: `so_oe_o` and `pdat_oe_o` are low whenever `cs_ni` is high.
- R11: Instruction 55h enters byte-wide mode and 45h leaves it, each with exactly 8 edges. Reset also leaves byte-wide mode.
- R12: In byte-wide mode the write data byte is taken from `pdat_i` at the 9th rising edge. A read (05h) drives the live status on `pdat_o` with `pdat_oe_o` high after the 8th edge, and `so_oe_o` stays low.
- R13: A frame with an unknown instruction or the wrong edge count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all host lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Active-low write-protect pin |
| pdat_i | input | 8 | Byte-wide write data |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Enable for so_o (low means high impedance) |
| pdat_o | output | 8 | Byte-wide status out |
| pdat_oe_o | output | 1 | Enable for pdat_o |

## Verification
The assertions assume that `sck_i`, `cs_ni` and `si_i` are synchronous to `clk_i`, that every SCK level lasts at least one clock, that SCK does not move in the cycle where `cs_ni` falls, and that `wp_ni` is steady around the rise of `cs_ni`. The stimulus meets these conditions. It changes inputs only on the falling clock edge. It holds each SCK phase for at least two clocks. It settles SCK to its idle level before it lowers chip select.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIT_CW  = $clog2(BYTE_W);
  localparam int unsigned BYTE_CW = 2;

  localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WR_EN   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_PAR_ON  = 8'h55;
  localparam logic [BYTE_W-1:0] OP_PAR_OFF = 8'h45;

  typedef struct packed {
    logic       wr_lock;
    logic [1:0] rsvd;
    logic [2:0] prot;
    logic       wr_en;
    logic       busy;
  } stat_t;
endpackage

// File: rtl/sfs_frame_rx.sv
module sfs_frame_rx
  import sfs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               si_i,
  output logic               rise_o,
  output logic               fall_o,
  output logic               end_o,
  output logic [BYTE_W-1:0]  op_o,
  output logic               op_vld_o,
  output logic [BYTE_CW-1:0] byte_cnt_o,
  output logic [BIT_CW-1:0]  bit_cnt_o,
  output logic [BYTE_W-1:0]  shift_o
);
  logic sck_q, cs_q;

  assign rise_o = ~cs_ni & sck_i & ~sck_q;
  assign fall_o = ~cs_ni & ~sck_i & sck_q;
  assign end_o  = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      shift_o    <= '0;
      op_o       <= '0;
      op_vld_o   <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        bit_cnt_o  <= '0;
        byte_cnt_o <= '0;
        op_vld_o   <= 1'b0;
      end else if (rise_o) begin
        shift_o   <= {shift_o[BYTE_W-2:0], si_i};
        bit_cnt_o <= bit_cnt_o + BIT_CW'(1);
        if (bit_cnt_o == {BIT_CW{1'b1}}) begin
          // byte counter saturates: frames longer than 3 bytes stay "long"
          if (byte_cnt_o != {BYTE_CW{1'b1}}) byte_cnt_o <= byte_cnt_o + BYTE_CW'(1);
          if (byte_cnt_o == '0) begin
            op_o     <= {shift_o[BYTE_W-2:0], si_i};
            op_vld_o <= 1'b1;
          end
        end
      end
    end
  end

  a_r13_frame_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_cnt_o == '0 && byte_cnt_o == '0 && !op_vld_o));
endmodule

// File: rtl/sfs_status_regs.sv
module sfs_status_regs
  import sfs_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  logic               end_i,
  input  logic [BYTE_W-1:0]  op_i,
  input  logic [BYTE_CW-1:0] byte_cnt_i,
  input  logic [BIT_CW-1:0]  bit_cnt_i,
  input  logic [BYTE_W-1:0]  ser_data_i,
  input  logic [BYTE_W-1:0]  pdat_i,
  input  logic               wp_ni,
  output stat_t              stat_o,
  output logic               par_mode_o
);
  localparam int unsigned TW = $clog2(BUSY_CYCLES + 1);

  logic             lock_q, wen_q, busy_q;
  logic [2:0]       prot_q;
  logic [TW-1:0]    tmr_q;
  logic [BYTE_W-1:0] par_q, wdat;
  logic             len8, len9, len16, wr_len, hw_lock, wren_ok, wr_ok;

  assign len8    = byte_cnt_i == BYTE_CW'(1) && bit_cnt_i == '0;
  assign len9    = byte_cnt_i == BYTE_CW'(1) && bit_cnt_i == BIT_CW'(1);
  assign len16   = byte_cnt_i == BYTE_CW'(2) && bit_cnt_i == '0;
  assign wr_len  = par_mode_o ? len9 : len16;
  assign hw_lock = lock_q & ~wp_ni;
  assign wdat    = par_mode_o ? par_q : ser_data_i;
  assign wren_ok = end_i & len8 & (op_i == OP_WR_EN) & ~busy_q;
  assign wr_ok   = end_i & wr_len & (op_i == OP_STAT_WR) & wen_q & ~busy_q & ~hw_lock;

  always_comb begin
    stat_o.wr_lock = lock_q;
    stat_o.rsvd    = 2'b00;
    stat_o.prot    = prot_q;
    stat_o.wr_en   = wen_q;
    stat_o.busy    = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      prot_q     <= '0;
      wen_q      <= 1'b0;
      busy_q     <= 1'b0;
      tmr_q      <= '0;
      par_q      <= '0;
      par_mode_o <= 1'b0;
    end else begin
      // byte-wide data is taken on the edge after the instruction byte
      if (par_mode_o && rise_i && len8) par_q <= pdat_i;
      if (wr_ok) begin
        lock_q <= wdat[7];
        prot_q <= wdat[4:2];
        busy_q <= 1'b1;
        tmr_q  <= TW'(BUSY_CYCLES - 1);
      end else if (busy_q) begin
        if (tmr_q == '0) begin
          busy_q <= 1'b0;
          wen_q  <= 1'b0;
        end else begin
          tmr_q <= tmr_q - TW'(1);
        end
      end
      if (wren_ok) wen_q <= 1'b1;
      if (end_i && len8) begin
        if (op_i == OP_PAR_ON)  par_mode_o <= 1'b1;
        if (op_i == OP_PAR_OFF) par_mode_o <= 1'b0;
      end
    end
  end

  a_r7_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(end_i && op_i == OP_STAT_WR));
  a_r7_wel_clear_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !wen_q);
  a_r3_wel_by_wren: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen_q) |-> $past(end_i && op_i == OP_WR_EN));
  a_r6_hw_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && lock_q && !wp_ni) |=> $stable({lock_q, prot_q}));
  a_r8_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable({lock_q, prot_q}));
  a_r11_mode_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(par_mode_o));
endmodule

// File: rtl/sfs_read_tx.sv
module sfs_read_tx
  import sfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] op_i,
  input  logic              op_vld_i,
  input  logic [BIT_CW-1:0] bit_cnt_i,
  input  logic              par_mode_i,
  input  stat_t             stat_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [BYTE_W-1:0] pdat_o,
  output logic              pdat_oe_o
);
  logic [BYTE_W-1:0] snap_q;
  logic              so_q, rd;

  assign rd        = op_vld_i & (op_i == OP_STAT_RD);
  assign so_oe_o   = ~cs_ni & rd & ~par_mode_i;
  assign pdat_oe_o = ~cs_ni & rd & par_mode_i;
  assign pdat_o    = pdat_oe_o ? stat_i : '0;
  assign so_o      = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      so_q   <= 1'b0;
    end else begin
      // re-capture at every byte boundary so polling sees fresh status
      if (rise_i && bit_cnt_i == {BIT_CW{1'b1}}) snap_q <= stat_i;
      if (fall_i && rd) so_q <= snap_q[~bit_cnt_i];
    end
  end

  a_r9_so_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(so_q));
endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
  import sfs_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       si_i,
  input  logic       wp_ni,
  input  logic [7:0] pdat_i,
  output logic       so_o,
  output logic       so_oe_o,
  output logic [7:0] pdat_o,
  output logic       pdat_oe_o
);
  logic               rise, fall, frame_end, op_vld, par_mode;
  logic [BYTE_W-1:0]  op, shift;
  logic [BYTE_CW-1:0] byte_cnt;
  logic [BIT_CW-1:0]  bit_cnt;
  stat_t              stat;

  sfs_frame_rx u_rx (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .rise_o(rise), .fall_o(fall), .end_o(frame_end),
    .op_o(op), .op_vld_o(op_vld), .byte_cnt_o(byte_cnt),
    .bit_cnt_o(bit_cnt), .shift_o(shift)
  );

  sfs_status_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk_i, .rst_ni, .rise_i(rise), .end_i(frame_end), .op_i(op),
    .byte_cnt_i(byte_cnt), .bit_cnt_i(bit_cnt), .ser_data_i(shift),
    .pdat_i, .wp_ni, .stat_o(stat), .par_mode_o(par_mode)
  );

  sfs_read_tx u_tx (
    .clk_i, .rst_ni, .cs_ni, .rise_i(rise), .fall_i(fall),
    .op_i(op), .op_vld_i(op_vld), .bit_cnt_i(bit_cnt),
    .par_mode_i(par_mode), .stat_i(stat),
    .so_o, .so_oe_o, .pdat_o, .pdat_oe_o
  );
endmodule

// File: tb/sflash_status_ctrl_bench.sv
module sflash_status_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int B     = 300;
  localparam int H     = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0, cs_ni = 1'b1, si_i = 1'b0, wp_ni = 1'b1;
  logic [7:0] pdat_i = '0;
  logic so_o, so_oe_o, pdat_oe_o;
  logic [7:0] pdat_o;

  int cyc = 0, nvec = 0, nerr = 0, last_rise_c = 0;
  bit done = 0;

  // reference model state
  bit m_lock, m_wel, m_par, m_pend;
  bit [2:0] m_prot;
  int m_busy_end;

  always #(CLK_P/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  sflash_status_ctrl #(.BUSY_CYCLES(B)) u_sflash_status_ctrl (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i, .wp_ni, .pdat_i,
    .so_o, .so_oe_o, .pdat_o, .pdat_oe_o
  );

  function automatic logic [7:0] m_stat(input int k);
    bit busy = m_pend && k < m_busy_end;
    bit wel  = (m_pend && k >= m_busy_end) ? 1'b0 : m_wel;
    return {m_lock, 2'b00, m_prot, wel, busy};
  endfunction

  task automatic m_frame_end(input logic [7:0] op, input int n, input logic [7:0] dat, input int c);
    bit busy;
    if (m_pend && c >= m_busy_end) begin m_wel = 0; m_pend = 0; end
    busy = m_pend;
    if (op == 8'h06 && n == 8 && !busy) m_wel = 1;
    if (op == 8'h55 && n == 8) m_par = 1;
    if (op == 8'h45 && n == 8) m_par = 0;
    if (op == 8'h01 && n == (m_par ? 9 : 16) && m_wel && !busy && !(m_lock && !wp_ni)) begin
      m_lock = dat[7];
      m_prot = dat[4:2];
      m_pend = 1;
      m_busy_end = c + 1 + B;
    end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // every-clock check of output enables against chip select (R10)
  always @(posedge clk_i) begin
    #(CLK_P/4);
    if (rst_ni && !done) begin
      chk({6'd0, so_oe_o, pdat_oe_o}, (cs_ni || (so_oe_o && pdat_oe_o)) ? 8'h00 : {6'd0, so_oe_o, pdat_oe_o},
          "R10 enables with CS high / both enables");
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; cs_ni = 1; sck_i = 0;
    m_lock = 0; m_wel = 0; m_par = 0; m_pend = 0; m_prot = 0; m_busy_end = 0;
    repeat (3) @(negedge clk_i);
    chk({6'd0, so_oe_o, pdat_oe_o}, 8'h00, "R1 enables in reset");
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic cs_low(input bit mode3);
    @(negedge clk_i);
    sck_i = mode3;
    repeat (H) @(negedge clk_i);
    cs_ni = 0;
    repeat (H) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    sck_i = 0; si_i = b;
    repeat (H) @(negedge clk_i);
    last_rise_c = cyc;
    sck_i = 1;
    repeat (H) @(negedge clk_i);
  endtask

  task automatic cs_high(input bit mode3, input logic [7:0] op, input int n, input logic [7:0] dat);
    if (!mode3) begin
      @(negedge clk_i); sck_i = 0;
      repeat (H) @(negedge clk_i);
    end
    @(negedge clk_i);
    cs_ni = 1;
    m_frame_end(op, n, dat, cyc);
    repeat (H + 2) @(negedge clk_i);
  endtask

  task automatic frame(input bit mode3, input logic [7:0] op, input logic [7:0] dat, input int n);
    pdat_i = dat;
    cs_low(mode3);
    for (int i = 0; i < n; i++)
      send_bit(i < 8 ? op[7-i] : (i < 16 ? dat[15-i] : 1'b0));
    cs_high(mode3, op, n, dat);
  endtask

  task automatic rd_ser(input bit mode3, input int nbytes, input string tag);
    logic [7:0] exp, got;
    cs_low(mode3);
    for (int i = 0; i < 8; i++) send_bit(8'h05 >> (7 - i));
    exp = m_stat(last_rise_c);
    chk({6'd0, so_oe_o, pdat_oe_o}, 8'h02, {tag, " R9 SO enabled after opcode"});
    for (int b = 0; b < nbytes; b++) begin
      for (int j = 0; j < 8; j++) begin
        @(negedge clk_i);
        sck_i = 0;
        repeat (H) @(negedge clk_i);
        got[7-j] = so_o;
        if (j == 7) last_rise_c = cyc;
        sck_i = 1;
        repeat (H) @(negedge clk_i);
      end
      chk(got, exp, {tag, " R9 serial status byte"});
      exp = m_stat(last_rise_c);
    end
    cs_high(mode3, 8'h05, 8 + 8 * nbytes, 8'h00);
    chk({7'd0, so_oe_o}, 8'h00, {tag, " R10 SO released"});
  endtask

  task automatic rd_par(input int ncyc, input string tag);
    cs_low(0);
    for (int i = 0; i < 8; i++) send_bit(8'h05 >> (7 - i));
    chk({6'd0, so_oe_o, pdat_oe_o}, 8'h01, {tag, " R12 byte-wide enable, SO off"});
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk_i);
      chk(pdat_o, m_stat(cyc), {tag, " R12 live status on pdat_o"});
    end
    cs_high(0, 8'h05, 8, 8'h00);
  endtask

  initial begin
    do_reset();
    rd_ser(0, 1, "R1 reset status");
    frame(0, 8'h01, 8'hFC, 16);
    rd_ser(0, 1, "R4 write without enable");
    frame(0, 8'h06, 8'h00, 8);
    rd_ser(1, 1, "R3 R2 enable latch, mode 3 read");
    frame(1, 8'h06, 8'h00, 8);
    frame(1, 8'h01, 8'hFF, 16);
    rd_ser(0, 2, "R5 R7 busy, two bytes");
    frame(0, 8'h01, 8'h00, 16);
    frame(1, 8'h06, 8'h00, 8);
    repeat (B + 20) @(negedge clk_i);
    rd_ser(0, 1, "R8 R7 busy ignored writes, latch cleared");
    frame(0, 8'h06, 8'h00, 8);
    frame(0, 8'h01, 8'h00, 15);
    frame(1, 8'h01, 8'h00, 17);
    rd_ser(0, 1, "R13 wrong length write");
    wp_ni = 0;
    frame(0, 8'h01, 8'h00, 16);
    rd_ser(0, 1, "R6 hardware lock");
    wp_ni = 1;
    frame(0, 8'h01, 8'h63, 16);
    repeat (B + 20) @(negedge clk_i);
    rd_ser(1, 1, "R5 R3 reserved and low bits not written");
    frame(0, 8'hAA, 8'h00, 8);
    frame(0, 8'h06, 8'h00, 9);
    rd_ser(0, 1, "R13 unknown op and long enable");
    frame(0, 8'h55, 8'h00, 8);
    rd_par(4, "R11 enter byte-wide");
    frame(0, 8'h06, 8'h00, 8);
    frame(0, 8'h01, 8'h1C, 16);
    rd_par(2, "R12 serial-length write in byte-wide");
    frame(0, 8'h01, 8'h1C, 9);
    rd_par(B + 40, "R7 R12 busy window");
    frame(0, 8'h45, 8'h00, 8);
    rd_ser(1, 1, "R11 exit byte-wide");
    frame(0, 8'h55, 8'h00, 8);
    do_reset();
    rd_ser(0, 1, "R11 reset leaves byte-wide");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule